// File: doc/BRIEF.md
# IPv4 In-Flight Header Rewrite Pipeline

This block sits in the receive path of a router port. Ethernet frames come in as a byte stream, one byte per cycle, with preamble and start delimiter already stripped, and a valid flag that is high for every byte of a frame. The block counts bytes within each frame and picks the destination MAC, the EtherType and the destination IPv4 address out of fixed offsets. On the cycle that the final address byte arrives it raises a lookup request carrying the full 32-bit address to an external next-hop engine.

Each byte, together with its valid flag, travels through a fixed-length delay line that gives the lookup engine time to answer before the frame leaves. As a routed IPv4 frame leaves, the block writes the next-hop MAC over the destination MAC and decrements the TTL. It adjusts the header checksum to match by incremental one's-complement arithmetic, and it drives an egress port mask for the whole frame. Frames addressed to this host are flagged for the host path instead of being rewritten. So are group-addressed frames and IPv4 frames that have run out of TTL. Frames whose lookup answer comes too late are dropped and counted.

Top module: `ip4_fwd_pipe`

## Requirements
- R1: After reset, outValid, outByte, outPortMask, outToHost, lkpReq and missCount are all zero.
- R2: A byte presented in the cycle before clock edge n leaves on outByte after edge n+DEPTH, so it is visible DEPTH+1 cycles after it was driven. outValid low on the delayed stream gives outValid low.
- R3: When routerEn is 1 and bridgeMode is 0, lkpReq is high for exactly the cycle in which frame byte 33 is on the input. lkpKey then equals bytes 30..33 of that frame, with byte 30 most significant.
- R4: A forwarded frame leaves with bytes 0..5 replaced by lkpRspMac, most significant byte first. outPortMask equals the reply's lkpRspPort for every byte of that frame and is zero whenever outValid is low.
- R5: A forwarded frame leaves with byte 22 (TTL) reduced by one. Bytes 24..25 then hold the correct IPv4 header checksum of the modified header. All other bytes are unchanged.
- R6: A frame is marked with outToHost, and is not rewritten, if byte 0 bit 0 (the group bit) is set, or if it is IPv4 (bytes 12..13 equal 0x0800) and its destination address equals ifaceAddr or 0.0.0.0.
- R7: An IPv4 frame with TTL 0 or 1 in router mode is passed out unchanged with outToHost set, and is never counted as a miss.
- R8: The reply is accepted up to and including the cycle in which the frame's byte 0 is the last delay stage. Without a reply by then, a frame that would be forwarded is dropped entirely and missCount increments by one, saturating.
- R9: With bridgeMode 1 or routerEn 0, no lookup is requested and frames pass out unchanged with a zero port mask.
- R10: Frames whose EtherType is not 0x0800, including IPv6 (0x86DD), pass out unchanged with a zero port mask even in router mode.
- R11: Byte counters restart at offset 0 after any cycle with valid low, so two frames separated by one idle cycle are each processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid, high throughout a frame |
| inByte | input | 8 | Input frame byte |
| routerEn | input | 1 | Enable routed forwarding |
| bridgeMode | input | 1 | Pass frames unchanged, no lookups |
| ifaceAddr | input | 32 | This interface's IPv4 address |
| lkpReq | output | 1 | Lookup request strobe |
| lkpKey | output | 32 | Destination IPv4 address to look up |
| lkpRspValid | input | 1 | Lookup reply strobe |
| lkpRspMac | input | 48 | Next-hop MAC address from the reply |
| lkpRspPort | input | PORTS | Egress port mask from the reply |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Output frame byte |
| outPortMask | output | PORTS | Egress mask for the frame being sent |
| outToHost | output | 1 | Frame belongs on the host path |
| missCount | output | MISS_W | Frames dropped for a late reply |

## Verification
The bench builds the block with its defaults: a 42-stage delay line, four egress ports, a 12-bit byte counter and a 16-bit miss counter. At that depth the reply window spans nine cycles after the request. A reply nine cycles late lands exactly on the acceptance cycle, and a reply ten cycles late causes a drop, so both sides of the deadline are exercised. The 64-byte frames are longer than the delay line, which makes the back-to-back case with a single idle cycle reachable. The test headers carry correct checksums, so the rewritten checksum can be checked against a full recomputation.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Byte offsets inside an Ethernet/IPv4 frame (preamble removed)
  localparam int OffMacLast  = 5;
  localparam int OffTypeHi   = 12;
  localparam int OffTypeLo   = 13;
  localparam int OffTtl      = 22;
  localparam int OffSumHi    = 24;
  localparam int OffSumLo    = 25;
  localparam int OffIpFirst  = 30;
  localparam int OffIpLast   = 33;

  localparam logic [15:0] EtypeIpv4 = 16'h0800;

  // Strobes from control to datapath for the byte leaving the delay line
  typedef struct packed {
    logic       useMac;
    logic [2:0] macSel;
    logic       useTtl;
    logic       useSumHi;
    logic       useSumLo;
    logic       kill;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PORTS  = 4,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              routerEn,
  input  logic              bridgeMode,
  input  logic [31:0]       ifaceAddr,
  input  logic              lkpRspValid,
  input  logic [47:0]       lkpRspMac,
  input  logic [PORTS-1:0]  lkpRspPort,
  input  logic              dValid,
  output logic              lkpReq,
  output logic [31:0]       lkpKey,
  output fwdStrobe_t        strobe,
  output logic [47:0]       nhMac,
  output logic [7:0]        hdrTtl,
  output logic [15:0]       hdrSum,
  output logic [PORTS-1:0]  outPortMask,
  output logic              outToHost,
  output logic [MISS_W-1:0] missCount
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  // ---------------- input side: counting and field capture
  logic [CNT_W-1:0] inCnt;
  logic [47:0] capMac;
  logic [15:0] capType;
  logic [31:0] capIp;
  logic [7:0]  capTtl;
  logic [15:0] capSum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inCnt   <= '0;
      capMac  <= '0;
      capType <= '0;
      capIp   <= '0;
      capTtl  <= '0;
      capSum  <= '0;
    end else if (!inValid) begin
      inCnt <= '0;
    end else begin
      if (inCnt != CntMax) inCnt <= inCnt + 1'b1;
      if (inCnt <= CNT_W'(OffMacLast)) capMac <= {capMac[39:0], inByte};
      if (inCnt == CNT_W'(OffTypeHi) || inCnt == CNT_W'(OffTypeLo))
        capType <= {capType[7:0], inByte};
      if (inCnt == CNT_W'(OffTtl)) capTtl <= inByte;
      if (inCnt == CNT_W'(OffSumHi) || inCnt == CNT_W'(OffSumLo))
        capSum <= {capSum[7:0], inByte};
      if (inCnt >= CNT_W'(OffIpFirst) && inCnt <= CNT_W'(OffIpLast))
        capIp <= {capIp[23:0], inByte};
    end
  end

  // Lookup launched in the very cycle the last address byte is present
  assign lkpReq = inValid && (inCnt == CNT_W'(OffIpLast)) && routerEn && !bridgeMode;
  assign lkpKey = {capIp[23:0], inByte};

  // ---------------- reply holding register
  logic             rspHeld;
  logic [47:0]      rspMac;
  logic [PORTS-1:0] rspPort;
  logic [CNT_W-1:0] outCnt;
  logic             frameStart;

  assign frameStart = dValid && (outCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspHeld <= 1'b0;
      rspMac  <= '0;
      rspPort <= '0;
    end else if (lkpRspValid) begin
      rspHeld <= 1'b1;
      rspMac  <= lkpRspMac;
      rspPort <= lkpRspPort;
    end else if (lkpReq || frameStart) begin
      rspHeld <= 1'b0;
    end
  end

  logic             rspAvail;
  logic [47:0]      rspMacNow;
  logic [PORTS-1:0] rspPortNow;
  assign rspAvail   = rspHeld || lkpRspValid;
  assign rspMacNow  = rspHeld ? rspMac  : lkpRspMac;
  assign rspPortNow = rspHeld ? rspPort : lkpRspPort;

  // ---------------- per-frame decision at output offset 0
  logic isV4, hostHit, routed, decFwd, decHost, decKill;
  assign isV4    = (capType == EtypeIpv4);
  assign hostHit = (isV4 && (capIp == ifaceAddr || capIp == '0)) || capMac[40];
  assign routed  = routerEn && !bridgeMode;
  assign decFwd  = routed && isV4 && !hostHit && (capTtl > 8'd1);
  assign decHost = hostHit || (routed && isV4 && (capTtl < 8'd2));
  assign decKill = decFwd && !rspAvail;

  logic             frmFwd, frmHost, frmKill;
  logic [47:0]      frmMac;
  logic [PORTS-1:0] frmMask;
  logic [7:0]       frmTtl;
  logic [15:0]      frmSum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frmFwd  <= 1'b0;
      frmHost <= 1'b0;
      frmKill <= 1'b0;
      frmMac  <= '0;
      frmMask <= '0;
      frmTtl  <= '0;
      frmSum  <= '0;
    end else if (frameStart) begin
      frmFwd  <= decFwd;
      frmHost <= decHost;
      frmKill <= decKill;
      frmMac  <= rspMacNow;
      frmMask <= rspPortNow;
      frmTtl  <= capTtl;
      frmSum  <= capSum;
    end
  end

  logic             curFwd, curHost, curKill;
  logic [PORTS-1:0] curMask;
  assign curFwd  = frameStart ? decFwd     : frmFwd;
  assign curHost = frameStart ? decHost    : frmHost;
  assign curKill = frameStart ? decKill    : frmKill;
  assign curMask = frameStart ? rspPortNow : frmMask;
  assign nhMac   = frameStart ? rspMacNow  : frmMac;
  assign hdrTtl  = frameStart ? capTtl     : frmTtl;
  assign hdrSum  = frameStart ? capSum     : frmSum;

  // ---------------- output side counter and strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           outCnt <= '0;
    else if (!dValid)     outCnt <= '0;
    else if (outCnt != CntMax) outCnt <= outCnt + 1'b1;
  end

  logic rewrite;
  assign rewrite = curFwd && !curKill;

  always_comb begin
    strobe          = '0;
    strobe.kill     = curKill;
    strobe.macSel   = outCnt[2:0];
    strobe.useMac   = rewrite && (outCnt <= CNT_W'(OffMacLast));
    strobe.useTtl   = rewrite && (outCnt == CNT_W'(OffTtl));
    strobe.useSumHi = rewrite && (outCnt == CNT_W'(OffSumHi));
    strobe.useSumLo = rewrite && (outCnt == CNT_W'(OffSumLo));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outPortMask <= '0;
      outToHost   <= 1'b0;
      missCount   <= '0;
    end else begin
      outPortMask <= (dValid && rewrite) ? curMask : '0;
      outToHost   <= dValid && !curKill && curHost;
      if (frameStart && decKill && missCount != {MISS_W{1'b1}})
        missCount <= missCount + 1'b1;
    end
  end

  // ---------------- assertions
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkpReq |=> !lkpReq);

  p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (missCount != $past(missCount)) |-> (missCount == $past(missCount) + 1'b1));

  p_miss_only_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> (missCount == $past(missCount)));
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DEPTH = 42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  fwdStrobe_t strobe,
  input  logic [47:0] nhMac,
  input  logic [7:0] hdrTtl,
  input  logic [15:0] hdrSum,
  output logic       dValid,
  output logic       outValid,
  output logic [7:0] outByte
);
  localparam int WORD_W = 9;

  // {valid, byte} words marching through the delay line
  logic [DEPTH-1:0][WORD_W-1:0] line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '0;
    else        line <= {line[DEPTH-2:0], {inValid, inByte}};
  end

  logic [7:0] dByte;
  assign dValid = line[DEPTH-1][8];
  assign dByte  = line[DEPTH-1][7:0];

  // Incremental checksum: TTL drop lowers the TTL/protocol word by 0x0100,
  // i.e. adds 0xFEFF in one's complement to the inverted checksum.
  logic [16:0] sumRaw;
  logic [15:0] sumFold, newSum;
  logic [7:0]  newTtl;
  assign sumRaw  = {1'b0, ~hdrSum} + 17'h0FEFF;
  assign sumFold = sumRaw[15:0] + {15'd0, sumRaw[16]};
  assign newSum  = ~sumFold;
  assign newTtl  = hdrTtl - 8'd1;

  logic [7:0] macByte;
  always_comb begin
    case (strobe.macSel)
      3'd0:    macByte = nhMac[47:40];
      3'd1:    macByte = nhMac[39:32];
      3'd2:    macByte = nhMac[31:24];
      3'd3:    macByte = nhMac[23:16];
      3'd4:    macByte = nhMac[15:8];
      default: macByte = nhMac[7:0];
    endcase
  end

  logic [7:0] muxByte;
  always_comb begin
    if (strobe.useMac)        muxByte = macByte;
    else if (strobe.useTtl)   muxByte = newTtl;
    else if (strobe.useSumHi) muxByte = newSum[15:8];
    else if (strobe.useSumLo) muxByte = newSum[7:0];
    else                      muxByte = dByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      outValid <= dValid && !strobe.kill;
      outByte  <= (dValid && !strobe.kill) ? muxByte : 8'd0;
    end
  end

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dValid |=> !outValid);

  p_kill_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dValid && $past(dValid)) |-> (strobe.kill == $past(strobe.kill)));

  p_one_rewrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.useMac, strobe.useTtl, strobe.useSumHi, strobe.useSumLo}) <= 1);
endmodule

// File: rtl/ip4_fwd_pipe.sv
module ip4_fwd_pipe
  import fwd_pkg::*;
#(
  parameter int DEPTH  = 42,
  parameter int PORTS  = 4,
  parameter int CNT_W  = 12,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              routerEn,
  input  logic              bridgeMode,
  input  logic [31:0]       ifaceAddr,
  output logic              lkpReq,
  output logic [31:0]       lkpKey,
  input  logic              lkpRspValid,
  input  logic [47:0]       lkpRspMac,
  input  logic [PORTS-1:0]  lkpRspPort,
  output logic              outValid,
  output logic [7:0]        outByte,
  output logic [PORTS-1:0]  outPortMask,
  output logic              outToHost,
  output logic [MISS_W-1:0] missCount
);
  fwdStrobe_t  strobe;
  logic        dValid;
  logic [47:0] nhMac;
  logic [7:0]  hdrTtl;
  logic [15:0] hdrSum;

  fwd_ctrl #(.CNT_W(CNT_W), .PORTS(PORTS), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .routerEn(routerEn), .bridgeMode(bridgeMode), .ifaceAddr(ifaceAddr),
    .lkpRspValid(lkpRspValid), .lkpRspMac(lkpRspMac), .lkpRspPort(lkpRspPort),
    .dValid(dValid), .lkpReq(lkpReq), .lkpKey(lkpKey), .strobe(strobe),
    .nhMac(nhMac), .hdrTtl(hdrTtl), .hdrSum(hdrSum),
    .outPortMask(outPortMask), .outToHost(outToHost), .missCount(missCount)
  );

  fwd_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .strobe(strobe), .nhMac(nhMac), .hdrTtl(hdrTtl), .hdrSum(hdrSum),
    .dValid(dValid), .outValid(outValid), .outByte(outByte)
  );

  p_mask_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (outPortMask == '0));

  p_host_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> !outToHost);
endmodule

// File: tb/ip4_fwd_pipe_tb.sv
module ip4_fwd_pipe_tb;
  localparam int DEPTH = 42;
  localparam int PORTS = 4;
  localparam int LEN   = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = 8'd0;
  logic routerEn = 1'b1, bridgeMode = 1'b0;
  logic [31:0] ifaceAddr = 32'hC0A80001;
  logic lkpReq;
  logic [31:0] lkpKey;
  logic lkpRspValid = 1'b0;
  logic [47:0] lkpRspMac = 48'h02AABBCCDDEE;
  logic [PORTS-1:0] lkpRspPort = 4'b0100;
  logic outValid, outToHost;
  logic [7:0] outByte;
  logic [PORTS-1:0] outPortMask;
  logic [15:0] missCount;

  ip4_fwd_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .routerEn(routerEn), .bridgeMode(bridgeMode), .ifaceAddr(ifaceAddr),
    .lkpReq(lkpReq), .lkpKey(lkpKey), .lkpRspValid(lkpRspValid),
    .lkpRspMac(lkpRspMac), .lkpRspPort(lkpRspPort), .outValid(outValid),
    .outByte(outByte), .outPortMask(outPortMask), .outToHost(outToHost),
    .missCount(missCount)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] txBuf [256];
  logic [7:0] expBuf[256];
  logic [7:0] cap   [256];
  int capCount, firstCyc, startCyc;
  logic [PORTS-1:0] cMask;
  logic cHost, cVary, capOn = 1'b0;

  always @(negedge clk) begin
    if (capOn && outValid) begin
      if (capCount == 0) begin
        firstCyc = cyc; cMask = outPortMask; cHost = outToHost;
      end else if (outPortMask != cMask || outToHost != cHost) cVary = 1'b1;
      if (capCount < 256) cap[capCount] = outByte;
      capCount++;
    end
  end

  // Lookup responder
  int rspDelay = 1, tmr = 0, reqCount = 0;
  logic rspOn = 1'b1;
  logic [31:0] lastKey;
  always @(negedge clk) begin
    lkpRspValid = 1'b0;
    if (tmr > 0) begin
      tmr--;
      if (tmr == 0) lkpRspValid = 1'b1;
    end
    if (lkpReq) begin
      reqCount++;
      lastKey = lkpKey;
      if (rspOn) begin
        if (rspDelay == 0) lkpRspValid = 1'b1;
        else tmr = rspDelay;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ipSum(input int base, input logic [7:0] ttlv);
    logic [31:0] acc = 0;
    for (int i = 0; i < 20; i += 2) begin
      logic [7:0] hi = txBuf[base+14+i], lo = txBuf[base+15+i];
      if (14 + i == 22) hi = ttlv;
      if (14 + i == 24) begin hi = 8'd0; lo = 8'd0; end
      acc += {hi, lo};
    end
    while (acc[31:16] != 0) acc = acc[15:0] + acc[31:16];
    return ~acc[15:0];
  endfunction

  task automatic buildFrame(input int base, input logic [47:0] mac, input logic [15:0] et,
                            input logic [7:0] ttl, input logic [31:0] ip, input bit fwd);
    logic [15:0] s, ns;
    for (int i = 0; i < LEN; i++) txBuf[base+i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) txBuf[base+i] = mac[8*(5-i) +: 8];
    txBuf[base+12] = et[15:8]; txBuf[base+13] = et[7:0];
    txBuf[base+14] = 8'h45; txBuf[base+15] = 8'h00;
    txBuf[base+16] = 8'h00; txBuf[base+17] = 8'h32;
    txBuf[base+22] = ttl;   txBuf[base+23] = 8'h11;
    txBuf[base+26] = 8'h0A; txBuf[base+27] = 8'h00;
    txBuf[base+28] = 8'h00; txBuf[base+29] = 8'h07;
    for (int i = 0; i < 4; i++) txBuf[base+30+i] = ip[8*(3-i) +: 8];
    s = ipSum(base, ttl);
    txBuf[base+24] = s[15:8]; txBuf[base+25] = s[7:0];
    for (int i = 0; i < LEN; i++) expBuf[base+i] = txBuf[base+i];
    if (fwd) begin
      for (int i = 0; i < 6; i++) expBuf[base+i] = lkpRspMac[8*(5-i) +: 8];
      expBuf[base+22] = ttl - 8'd1;
      ns = ipSum(base, ttl - 8'd1);
      expBuf[base+24] = ns[15:8]; expBuf[base+25] = ns[7:0];
    end
  endtask

  // Send n words from txBuf; index gapAt (if >=0) is an idle cycle
  task automatic sendRaw(input int n, input int gapAt);
    int src = 0;
    capCount = 0; cVary = 1'b0; capOn = 1'b1; reqCount = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i == 0) startCyc = cyc;
      if (i == gapAt) begin inValid = 1'b0; inByte = 8'd0; end
      else begin inValid = 1'b1; inByte = txBuf[src]; src++; end
    end
    @(posedge clk); #1;
    inValid = 1'b0; inByte = 8'd0;
    repeat (DEPTH + 6) @(posedge clk);
    capOn = 1'b0;
  endtask

  task automatic cmpFrame(input string req, input int n);
    int bad = -1;
    for (int i = 0; i < n && i < 256; i++) if (bad < 0 && cap[i] !== expBuf[i]) bad = i;
    chk(capCount == n, req, "byte count", capCount, n);
    if (bad >= 0) chk(1'b0, req, $sformatf("byte %0d", bad), cap[bad], expBuf[bad]);
    else chk(1'b1, req, "bytes", 0, 0);
  endtask

  task automatic tReset();
    chk(!outValid && outByte == 0, "R1", "outValid/outByte", {outValid, outByte}, 0);
    chk(outPortMask == 0 && !outToHost, "R1", "mask/host", {outPortMask, outToHost}, 0);
    chk(missCount == 0 && !lkpReq, "R1", "missCount/lkpReq", {missCount, lkpReq}, 0);
  endtask

  task automatic tForward();
    rspDelay = 1;
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd64, 32'h0A010203, 1'b1);
    sendRaw(LEN, -1);
    chk(reqCount == 1, "R3", "request count", reqCount, 1);
    chk(lastKey == 32'h0A010203, "R3", "lookup key", lastKey, 32'h0A010203);
    chk(firstCyc - startCyc == DEPTH + 1, "R2", "latency", firstCyc - startCyc, DEPTH + 1);
    chk({cap[0], cap[5]} == {lkpRspMac[47:40], lkpRspMac[7:0]}, "R4", "next-hop MAC",
        {cap[0], cap[5]}, {lkpRspMac[47:40], lkpRspMac[7:0]});
    chk(cMask == 4'b0100 && !cVary, "R4", "port mask", cMask, 4'b0100);
    cmpFrame("R5", LEN);
    chk(outPortMask == 0, "R4", "mask after frame", outPortMask, 0);
  endtask

  task automatic tDeadline();
    rspDelay = 9;
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd17, 32'h0B0C0D0E, 1'b1);
    sendRaw(LEN, -1);
    cmpFrame("R8", LEN);
    chk(missCount == 0, "R8", "no miss at deadline", missCount, 0);
    rspDelay = 10;
    sendRaw(LEN, -1);
    chk(capCount == 0, "R8", "late frame dropped", capCount, 0);
    chk(missCount == 1, "R8", "miss counted", missCount, 1);
    rspDelay = 1;
  endtask

  task automatic tBridge();
    bridgeMode = 1'b1;
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd64, 32'h0A010203, 1'b0);
    sendRaw(LEN, -1);
    chk(reqCount == 0, "R9", "no request in bridge mode", reqCount, 0);
    cmpFrame("R9", LEN);
    chk(cMask == 0, "R9", "bridge mask", cMask, 0);
    bridgeMode = 1'b0; routerEn = 1'b0;
    sendRaw(LEN, -1);
    chk(reqCount == 0, "R9", "no request with router off", reqCount, 0);
    cmpFrame("R9", LEN);
    routerEn = 1'b1;
  endtask

  task automatic tNonV4();
    buildFrame(0, 48'h001122334455, 16'h86DD, 8'd64, 32'h0A010203, 1'b0);
    sendRaw(LEN, -1);
    cmpFrame("R10", LEN);
    chk(cMask == 0 && cHost == 0, "R10", "mask/host", {cMask, cHost}, 0);
  endtask

  task automatic tHost();
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd64, ifaceAddr, 1'b0);
    sendRaw(LEN, -1);
    cmpFrame("R6", LEN);
    chk(cHost && cMask == 0, "R6", "own address to host", {cHost, cMask}, 5'b10000);
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd64, 32'h0, 1'b0);
    sendRaw(LEN, -1);
    chk(cHost == 1'b1, "R6", "zero address to host", cHost, 1);
    buildFrame(0, 48'h010203040506, 16'h0800, 8'd64, 32'h0A010203, 1'b0);
    sendRaw(LEN, -1);
    cmpFrame("R6", LEN);
    chk(cHost == 1'b1, "R6", "group MAC to host", cHost, 1);
  endtask

  task automatic tTtl();
    logic [15:0] m0 = missCount;
    rspOn = 1'b0;
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd1, 32'h0A010203, 1'b0);
    sendRaw(LEN, -1);
    cmpFrame("R7", LEN);
    chk(cHost == 1'b1, "R7", "TTL 1 to host", cHost, 1);
    buildFrame(0, 48'h001122334455, 16'h0800, 8'd0, 32'h0A010203, 1'b0);
    sendRaw(LEN, -1);
    cmpFrame("R7", LEN);
    chk(missCount == m0, "R7", "no miss for expired TTL", missCount, m0);
    rspOn = 1'b1;
  endtask

  task automatic tBackToBack();
    rspDelay = 2;
    buildFrame(0,   48'h001122334455, 16'h0800, 8'd9,   32'h0A010203, 1'b1);
    buildFrame(LEN, 48'h00AA22334455, 16'h0800, 8'd200, 32'h14151617, 1'b1);
    sendRaw(2 * LEN + 1, LEN);
    chk(reqCount == 2, "R11", "two requests", reqCount, 2);
    chk(lastKey == 32'h14151617, "R11", "second key", lastKey, 32'h14151617);
    cmpFrame("R11", 2 * LEN);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 tReset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    tForward();
    tDeadline();
    tBridge();
    tNonV4();
    tHost();
    tTtl();
    tBackToBack();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule